// File: doc/BRIEF.md
# Sub-Hexagon Reference Mapper and Level Translator

This block is the glue between a multilevel space vector modulator and its two-level core. On every clock cycle it takes the reference vector in 60-degree integer coordinates and the level triple of the currently active sub-hexagon center. It shifts the reference onto the central two-level hexagon by subtracting the space vector of that center. In the same cycle it takes the 3-bit switching code chosen by the two-level modulator and turns it back into three multilevel phase levels by adding the center level to each phase bit. The mapping and the translation both take one step, whatever the number of levels. Because the translation is a plain per-phase addition, the order of switching and the dwell of each state are exactly those of the two-level code stream.

The active sub-hexagon is chosen outside the block. A level triple (a, b, c) has coordinates m = a - b and n = b - c. Triples that differ by a common offset in all three phases fall on the same point. A phase level runs from 0 to LEVELS-1. If the center plus a code bit would go past the top level, the block raises an error flag and keeps its previous phase levels.

Top module: `subhex_mapper`

## Requirements
- R1: While `rstN` is low, all three phase levels, both mapped coordinates and `rangeErr` are 0.
- R2: `mapM` equals `refM - (centerA - centerB)`, taken modulo 2^COORD_W as a signed value.
- R3: `mapN` equals `refN - (centerB - centerC)`, taken modulo 2^COORD_W as a signed value.
- R4: Every output is registered. A change at the inputs shows at the outputs after the next rising clock edge and not before it.
- R5: When the translation is in range, the phase levels are `levelA = centerA + swCode[2]`, `levelB = centerB + swCode[1]` and `levelC = centerC + swCode[0]`.
- R6: Two centers that differ by the same offset in all phases (for example 300 and 411) give identical mapped coordinates for the same reference.
- R7: If any phase sum of center plus code bit exceeds LEVELS-1, `rangeErr` is 1 after the edge and all three phase levels keep their previous values. The mapped coordinates still update.
- R8: `rangeErr` goes back to 0 on the first in-range cycle, and the levels load the new sums.
- R9: A phase level output never exceeds LEVELS-1.
- R10: A phase sum exactly equal to LEVELS-1 is in range and is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refM | input | COORD_W | Reference m coordinate, signed |
| refN | input | COORD_W | Reference n coordinate, signed |
| centerA | input | LVL_W | Center level, phase A |
| centerB | input | LVL_W | Center level, phase B |
| centerC | input | LVL_W | Center level, phase C |
| swCode | input | 3 | Two-level code, bit 2 = A, bit 1 = B, bit 0 = C |
| mapM | output | COORD_W | Mapped m coordinate, signed |
| mapN | output | COORD_W | Mapped n coordinate, signed |
| levelA | output | LVL_W | Multilevel phase A level |
| levelB | output | LVL_W | Multilevel phase B level |
| levelC | output | LVL_W | Multilevel phase C level |
| rangeErr | output | 1 | Center plus code went past the top level |

## Verification
The bench drives each code bit on its own, so that a design with the bit order of `swCode` reversed produces swapped phase levels. It drives centers with negative coordinate parts, which a design with the wrong sign in the subtraction turns into a mapped vector on the wrong side of the origin. The top level is tested both exactly reached and exceeded by one: an off-by-one comparison would either reject the 555 center or load a level of 6. After an overflow the bench checks that the levels are held and that the flag clears on the next legal cycle, so a design that clears the levels or leaves the error flag set is caught.

// File: rtl/subhex_pkg.sv
package subhex_pkg;
  // Strobes sent from the range control to the datapath
  typedef struct packed {
    logic loadLevels;
    logic raiseErr;
  } mapStrobe_t;

  localparam int PHASES = 3;
endpackage

// File: rtl/subhex_ctrl.sv
module subhex_ctrl
  import subhex_pkg::*;
#(
  parameter int LEVELS = 6,
  parameter int LVL_W  = 3
) (
  input  logic [LVL_W-1:0] centerLvl [PHASES],
  input  logic [2:0]       swCode,
  output mapStrobe_t       strobe
);
  localparam int SUM_W = LVL_W + 1;
  localparam logic [SUM_W-1:0] TOP_LVL = SUM_W'(LEVELS - 1);

  logic [PHASES-1:0] overTop;

  // swCode bit 2 drives phase A (index 0), bit 0 drives phase C
  for (genvar p = 0; p < PHASES; p++) begin : g_rangeChk
    logic [SUM_W-1:0] phaseSum;
    assign phaseSum   = {1'b0, centerLvl[p]} + SUM_W'(swCode[PHASES-1-p]);
    assign overTop[p] = phaseSum > TOP_LVL;
  end

  always_comb begin
    strobe.raiseErr   = |overTop;
    strobe.loadLevels = ~(|overTop);
  end
endmodule

// File: rtl/subhex_datapath.sv
module subhex_datapath
  import subhex_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int COORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mapStrobe_t                strobe,
  input  logic signed [COORD_W-1:0] refM,
  input  logic signed [COORD_W-1:0] refN,
  input  logic [LVL_W-1:0]          centerLvl [PHASES],
  input  logic [2:0]                swCode,
  output logic signed [COORD_W-1:0] mapM,
  output logic signed [COORD_W-1:0] mapN,
  output logic [LVL_W-1:0]          levelQ [PHASES],
  output logic                      errQ
);
  localparam int PAD_W = COORD_W - LVL_W;

  logic signed [COORD_W-1:0] ctrWide [PHASES];
  logic signed [COORD_W-1:0] ctrM, ctrN;
  logic [LVL_W-1:0]          levelNext [PHASES];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign ctrWide[p]   = $signed({{PAD_W{1'b0}}, centerLvl[p]});
    assign levelNext[p] = centerLvl[p] + LVL_W'(swCode[PHASES-1-p]);

    always_ff @(posedge clk) begin
      if (!rstN)
        levelQ[p] <= '0;
      else if (strobe.loadLevels)
        levelQ[p] <= levelNext[p];
    end
  end

  // Center in 60-degree coordinates: m = a - b, n = b - c
  assign ctrM = ctrWide[0] - ctrWide[1];
  assign ctrN = ctrWide[1] - ctrWide[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapM <= '0;
      mapN <= '0;
      errQ <= 1'b0;
    end else begin
      mapM <= refM - ctrM;
      mapN <= refN - ctrN;
      errQ <= strobe.raiseErr;
    end
  end
endmodule

// File: rtl/subhex_mapper.sv
module subhex_mapper
  import subhex_pkg::*;
#(
  parameter int LEVELS  = 6,
  parameter int COORD_W = 8,
  localparam int LVL_W  = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [COORD_W-1:0] refM,
  input  logic signed [COORD_W-1:0] refN,
  input  logic [LVL_W-1:0]          centerA,
  input  logic [LVL_W-1:0]          centerB,
  input  logic [LVL_W-1:0]          centerC,
  input  logic [2:0]                swCode,
  output logic signed [COORD_W-1:0] mapM,
  output logic signed [COORD_W-1:0] mapN,
  output logic [LVL_W-1:0]          levelA,
  output logic [LVL_W-1:0]          levelB,
  output logic [LVL_W-1:0]          levelC,
  output logic                      rangeErr
);
  mapStrobe_t       strobe;
  logic [LVL_W-1:0] centerLvl [PHASES];
  logic [LVL_W-1:0] levelQ [PHASES];

  assign centerLvl[0] = centerA;
  assign centerLvl[1] = centerB;
  assign centerLvl[2] = centerC;

  subhex_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .centerLvl(centerLvl),
    .swCode   (swCode),
    .strobe   (strobe)
  );

  subhex_datapath #(.LVL_W(LVL_W), .COORD_W(COORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .refM     (refM),
    .refN     (refN),
    .centerLvl(centerLvl),
    .swCode   (swCode),
    .mapM     (mapM),
    .mapN     (mapN),
    .levelQ   (levelQ),
    .errQ     (rangeErr)
  );

  assign levelA = levelQ[0];
  assign levelB = levelQ[1];
  assign levelC = levelQ[2];
endmodule

// File: rtl/subhex_mapper_chk.sv
module subhex_mapper_chk #(
  parameter int LEVELS  = 6,
  parameter int COORD_W = 8,
  localparam int LVL_W  = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic signed [COORD_W-1:0] refM,
  input logic signed [COORD_W-1:0] refN,
  input logic [LVL_W-1:0]          centerA,
  input logic [LVL_W-1:0]          centerB,
  input logic [LVL_W-1:0]          centerC,
  input logic [2:0]                swCode,
  input logic signed [COORD_W-1:0] mapM,
  input logic signed [COORD_W-1:0] mapN,
  input logic [LVL_W-1:0]          levelA,
  input logic [LVL_W-1:0]          levelB,
  input logic [LVL_W-1:0]          levelC,
  input logic                      rangeErr
);
  logic signed [COORD_W-1:0] expM, expN;
  logic inRange;

  always_comb begin
    expM = refM - COORD_W'(centerA) + COORD_W'(centerB);
    expN = refN - COORD_W'(centerB) + COORD_W'(centerC);
    inRange = (int'(centerA) + int'(swCode[2]) <= LEVELS - 1) &&
              (int'(centerB) + int'(swCode[1]) <= LEVELS - 1) &&
              (int'(centerC) + int'(swCode[0]) <= LEVELS - 1);
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (levelA == 0 && levelB == 0 && levelC == 0 &&
               mapM == 0 && mapN == 0 && !rangeErr));

  // R2 and R3 (latency per R4)
  a_r2_map_m: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> mapM == $past(expM));
  a_r3_map_n: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> mapN == $past(expN));

  // R5
  a_r5_translate: assert property (@(posedge clk) disable iff (!rstN)
    inRange |=> (int'(levelA) == $past(int'(centerA) + int'(swCode[2])) &&
                 int'(levelB) == $past(int'(centerB) + int'(swCode[1])) &&
                 int'(levelC) == $past(int'(centerC) + int'(swCode[0])) &&
                 !rangeErr));

  // R7
  a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |=> (rangeErr && $stable(levelA) && $stable(levelB) && $stable(levelC)));

  // R9
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(levelA) <= LEVELS - 1 && int'(levelB) <= LEVELS - 1 && int'(levelC) <= LEVELS - 1);
endmodule

bind subhex_mapper subhex_mapper_chk #(.LEVELS(LEVELS), .COORD_W(COORD_W)) u_chk (.*);

// File: tb/test_subhex_mapper.sv
module test_subhex_mapper;
  localparam int LEVELS  = 6;
  localparam int COORD_W = 8;
  localparam int LVL_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [COORD_W-1:0] refM = '0, refN = '0;
  logic [LVL_W-1:0] centerA = '0, centerB = '0, centerC = '0;
  logic [2:0] swCode = '0;
  logic signed [COORD_W-1:0] mapM, mapN;
  logic [LVL_W-1:0] levelA, levelB, levelC;
  logic rangeErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  subhex_mapper #(.LEVELS(LEVELS), .COORD_W(COORD_W)) i_subhex_mapper (
    .clk(clk), .rstN(rstN), .refM(refM), .refN(refN),
    .centerA(centerA), .centerB(centerB), .centerC(centerC), .swCode(swCode),
    .mapM(mapM), .mapN(mapN), .levelA(levelA), .levelB(levelB), .levelC(levelC),
    .rangeErr(rangeErr)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample 1ns later
  task automatic apply(input int rm, input int rn, input int a, input int b,
                       input int c, input int code);
    @(negedge clk);
    refM = COORD_W'(rm); refN = COORD_W'(rn);
    centerA = LVL_W'(a); centerB = LVL_W'(b); centerC = LVL_W'(c);
    swCode = 3'(code);
    @(posedge clk);
    #1;
  endtask

  task automatic checkLevels(input string req, input int a, input int b, input int c);
    check(req, int'(levelA), a);
    check(req, int'(levelB), b);
    check(req, int'(levelC), c);
  endtask

  task automatic testReset;
    rstN = 1'b0;
    apply(9, -4, 5, 2, 1, 7);
    check("R1 mapM", int'(mapM), 0);
    check("R1 mapN", int'(mapN), 0);
    checkLevels("R1 level", 0, 0, 0);
    check("R1 err", int'(rangeErr), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testMapping;
    // center 440: m = 0, n = 4
    apply(7, -3, 4, 4, 0, 0);
    check("R2 mapM 440", int'(mapM), 7);
    check("R3 mapN 440", int'(mapN), -7);
    // center 000
    apply(2, 1, 0, 0, 0, 0);
    check("R2 mapM 000", int'(mapM), 2);
    check("R3 mapN 000", int'(mapN), 1);
    // center 022: m = -2, n = 0
    apply(0, 5, 0, 2, 2, 0);
    check("R2 mapM 022", int'(mapM), 2);
    check("R3 mapN 022", int'(mapN), 5);
  endtask

  task automatic testLatency;
    apply(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    refM = 8'sd20; centerA = 3'd3; swCode = 3'b100;
    #1;
    check("R4 mapM held before edge", int'(mapM), 1);
    check("R4 levelA held before edge", int'(levelA), 0);
    @(posedge clk);
    #1;
    check("R4 mapM after edge", int'(mapM), 17);
    check("R4 levelA after edge", int'(levelA), 4);
  endtask

  task automatic testTranslate;
    apply(0, 0, 4, 4, 0, 3'b100);
    checkLevels("R5 440+100", 5, 4, 0);
    apply(0, 0, 4, 4, 0, 3'b011);
    checkLevels("R5 440+011", 4, 5, 1);
    apply(0, 0, 0, 2, 2, 3'b111);
    checkLevels("R5 022+111", 1, 3, 3);
    apply(0, 0, 1, 0, 3, 3'b010);
    checkLevels("R5 103+010", 1, 1, 3);
  endtask

  task automatic testRedundant;
    int m1, n1;
    apply(6, 2, 3, 0, 0, 3'b000);
    m1 = int'(mapM); n1 = int'(mapN);
    checkLevels("R6 300 levels", 3, 0, 0);
    apply(6, 2, 4, 1, 1, 3'b000);
    check("R6 411 mapM", int'(mapM), m1);
    check("R6 411 mapN", int'(mapN), n1);
    checkLevels("R6 411 levels", 4, 1, 1);
  endtask

  task automatic testOverflow;
    apply(0, 0, 4, 4, 0, 3'b000);
    checkLevels("R7 preload", 4, 4, 0);
    apply(9, 0, 5, 4, 0, 3'b100);
    check("R7 err set", int'(rangeErr), 1);
    checkLevels("R7 levels held", 4, 4, 0);
    check("R7 map still updates", int'(mapM), 8);
    apply(0, 0, 2, 1, 0, 3'b001);
    check("R8 err cleared", int'(rangeErr), 0);
    checkLevels("R8 levels reload", 2, 1, 1);
  endtask

  task automatic testBoundary;
    apply(0, 0, 5, 5, 5, 3'b000);
    check("R10 top accepted err", int'(rangeErr), 0);
    checkLevels("R10 top level", 5, 5, 5);
    apply(0, 0, 5, 5, 5, 3'b001);
    check("R10 top plus one err", int'(rangeErr), 1);
    checkLevels("R9 bound held", 5, 5, 5);
    apply(0, 0, 4, 4, 4, 3'b111);
    check("R10 4+1 err", int'(rangeErr), 0);
    checkLevels("R10 4+1 level", 5, 5, 5);
  endtask

  initial begin
    testReset();
    testMapping();
    testLatency();
    testTranslate();
    testRedundant();
    testOverflow();
    testBoundary();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule